// File: doc/BRIEF.md
# Graphics Controller Host Bus Interface

This block is the processor side of a display controller. A host drives an 8-bit data bus, one address bit and separate write and read strobes. There is no select line, so the block acts on every strobe. A write puts one 9-bit entry into a shared queue. The address bit decides whether the byte is tagged as a command (address 1) or as a parameter (address 0). An internal consumer drains that queue in arrival order through a valid/pop pair.

On a read, address 0 returns a packed status byte. Address 1 returns the oldest byte of a second queue, which internal logic fills with results for the host. The status byte combines the state of both queues with five flags that arrive from the controller's drawing and video timing logic.

The strobes are sampled on the system clock and only their rising edges are acted on. A strobe held high for several cycles therefore causes exactly one push or one pop.

Top module: `gfxHostIf`

## Requirements
- R1: On a sampled rising edge of `hostWr`, the byte on `hostDin` is appended to the command queue. The tag bit `cmdIsCmd` is 1 when `hostAddr` is 1 and 0 when `hostAddr` is 0. The consumer sees entries in write order on `cmdValid`, `cmdIsCmd` and `cmdData`, and `cmdPop` removes the head entry.
- R2: Each rising edge of a strobe acts once. A strobe held high over several clock edges enqueues or dequeues only one entry.
- R3: A write arriving while the command queue holds `CMD_DEPTH` (16) entries is discarded and sets `overflowErr`. The flag stays set until reset. A consumer pop in the same cycle does not make room for that write.
- R4: The status byte has data ready in bit 0, meaning the result queue is not empty. Bit 1 means the command queue is full. Bit 2 means the command queue is empty.
- R5: Status bits 3 to 7 carry, in order, `drawBusy`, `dmaBusy`, `vsyncActive`, `hblankActive` and `penValid`, as sampled in the read cycle.
- R6: A read at address 1 while data ready is 1 returns the oldest result byte and removes it. Results come back in push order, and up to `RDQ_DEPTH` (8) are held.
- R7: A read at address 1 while data ready is 0 returns 0x00 and leaves the result queue unchanged.
- R8: `hostDout` is loaded at the clock edge that samples the read rising edge. It holds its value until the next read, whatever writes, pushes or pops occur in between.
- R9: After reset, both queues are empty, `cmdValid`, `overflowErr` and `rdqFull` are 0, and `hostDout` is 0x00.
- R10: `rdqPush` appends `rdqData` to the result queue unless the queue is full (`rdqFull` = 1), in which case the byte is discarded. A host pop and a producer push in the same cycle are both carried out when the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 1 | Host address bit |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Host read data, registered |
| overflowErr | output | 1 | Sticky dropped-write flag |
| cmdValid | output | 1 | Command queue has a head entry |
| cmdIsCmd | output | 1 | Head entry tag, 1 = command |
| cmdData | output | 8 | Head entry byte |
| cmdPop | input | 1 | Consumer removes head entry |
| rdqPush | input | 1 | Producer appends a result byte |
| rdqData | input | 8 | Result byte |
| rdqFull | output | 1 | Result queue full |
| drawBusy | input | 1 | Drawing in progress flag |
| dmaBusy | input | 1 | DMA execute flag |
| vsyncActive | input | 1 | Vertical sync flag |
| hblankActive | input | 1 | Horizontal blank flag |
| penValid | input | 1 | Light-pen detect flag |

## Verification
Two pairs of functions can land in the same cycle. In the first, a host write and a consumer pop hit the command queue together. In the second, a host data read and a producer push hit the result queue together. The bench raises both members of a pair on the same clock edge, both at random and in directed cases with the queue empty, partly filled and full. A reference model then applies the pop-then-push rule and the full-at-start rule. It compares the head entry, the data returned, `rdqFull` and the overflow flag after every such cycle.

// File: rtl/gfxHifPkg.sv
package gfxHifPkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic cmdPush;   // enqueue host byte into command queue
    logic cmdTag;    // 1 = command, 0 = parameter
    logic setOvf;    // write arrived while queue full
    logic capture;   // load host read register
    logic selData;   // capture result byte instead of status
    logic qPop;      // remove head of result queue
  } ctlStrobes_t;
endpackage

// File: rtl/gfxHifFifo.sv
module gfxHifFifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/gfxHifCtrl.sv
module gfxHifCtrl
  import gfxHifPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostAddr,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic        cmdFull,
  input  logic        dataReady,
  output ctlStrobes_t ctlStb
);
  logic prevWr, prevRd;
  logic wrRise, rdRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWr <= 1'b0;
      prevRd <= 1'b0;
    end else begin
      prevWr <= hostWr;
      prevRd <= hostRd;
    end
  end

  assign wrRise = hostWr && !prevWr;
  assign rdRise = hostRd && !prevRd;

  always_comb begin
    ctlStb         = '0;
    ctlStb.cmdTag  = hostAddr;
    ctlStb.cmdPush = wrRise && !cmdFull;
    ctlStb.setOvf  = wrRise && cmdFull;
    ctlStb.capture = rdRise;
    ctlStb.selData = hostAddr;
    ctlStb.qPop    = rdRise && hostAddr && dataReady;
  end
endmodule

// File: rtl/gfxHifDatapath.sv
module gfxHifDatapath
  import gfxHifPkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RDQ_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctlStb,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  output logic              overflowErr,
  output logic              cmdValid,
  output logic              cmdIsCmd,
  output logic [DATA_W-1:0] cmdData,
  input  logic              cmdPop,
  input  logic              rdqPush,
  input  logic [DATA_W-1:0] rdqData,
  output logic              rdqFull,
  input  logic [4:0]        extFlags,
  output logic              cmdFull,
  output logic              dataReady
);
  localparam int ENTRY_W = DATA_W + 1;

  logic [ENTRY_W-1:0] cmdHead;
  logic               cmdEmpty;
  logic [DATA_W-1:0]  rdqHead;
  logic               rdqEmpty;
  logic [DATA_W-1:0]  statusByte;

  gfxHifFifo #(.WIDTH(ENTRY_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rstN(rstN),
    .push(ctlStb.cmdPush), .din({ctlStb.cmdTag, hostDin}),
    .pop(cmdPop), .head(cmdHead), .full(cmdFull), .empty(cmdEmpty)
  );

  gfxHifFifo #(.WIDTH(DATA_W), .DEPTH(RDQ_DEPTH)) u_rdq (
    .clk(clk), .rstN(rstN),
    .push(rdqPush), .din(rdqData),
    .pop(ctlStb.qPop), .head(rdqHead), .full(rdqFull), .empty(rdqEmpty)
  );

  assign dataReady  = !rdqEmpty;
  assign cmdValid   = !cmdEmpty;
  assign cmdIsCmd   = cmdHead[DATA_W];
  assign cmdData    = cmdHead[DATA_W-1:0];
  assign statusByte = {extFlags, cmdEmpty, cmdFull, dataReady};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostDout    <= '0;
      overflowErr <= 1'b0;
    end else begin
      if (ctlStb.setOvf) overflowErr <= 1'b1;
      if (ctlStb.capture) begin
        if (!ctlStb.selData)  hostDout <= statusByte;
        else if (dataReady)   hostDout <= rdqHead;
        else                  hostDout <= '0;
      end
    end
  end
endmodule

// File: rtl/gfxHostIf.sv
module gfxHostIf
  import gfxHifPkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RDQ_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostDin,
  output logic [7:0] hostDout,
  output logic       overflowErr,
  output logic       cmdValid,
  output logic       cmdIsCmd,
  output logic [7:0] cmdData,
  input  logic       cmdPop,
  input  logic       rdqPush,
  input  logic [7:0] rdqData,
  output logic       rdqFull,
  input  logic       drawBusy,
  input  logic       dmaBusy,
  input  logic       vsyncActive,
  input  logic       hblankActive,
  input  logic       penValid
);
  ctlStrobes_t ctlStb;
  logic        cmdFull;
  logic        dataReady;

  gfxHifCtrl u_ctl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .cmdFull(cmdFull), .dataReady(dataReady),
    .ctlStb(ctlStb)
  );

  gfxHifDatapath #(.CMD_DEPTH(CMD_DEPTH), .RDQ_DEPTH(RDQ_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctlStb(ctlStb), .hostDin(hostDin),
    .hostDout(hostDout), .overflowErr(overflowErr), .cmdValid(cmdValid),
    .cmdIsCmd(cmdIsCmd), .cmdData(cmdData), .cmdPop(cmdPop),
    .rdqPush(rdqPush), .rdqData(rdqData), .rdqFull(rdqFull),
    .extFlags({penValid, hblankActive, vsyncActive, dmaBusy, drawBusy}),
    .cmdFull(cmdFull), .dataReady(dataReady)
  );
endmodule

// File: rtl/gfxHostIfChecker.sv
module gfxHostIfChecker (
  input logic       clk,
  input logic       rstN,
  input logic       hostAddr,
  input logic       hostWr,
  input logic       hostRd,
  input logic [7:0] hostDout,
  input logic       overflowErr,
  input logic       cmdValid,
  input logic       cmdPush,
  input logic       dataReady
);
  // R3: the error flag never clears without reset
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  // R3: the flag can only rise after a write strobe was seen
  assert_ovf_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowErr) |-> $past(hostWr));

  // R8: the read register changes only after a read strobe was sampled
  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostRd) |-> $stable(hostDout));

  // R7: a data read with nothing queued returns zero
  assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !$past(hostRd) && hostAddr && !dataReady) |=> (hostDout == 8'h00));

  // R1: an accepted write leaves the command queue non-empty
  assert_push_visible_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdPush |=> cmdValid);
endmodule

bind gfxHostIf gfxHostIfChecker u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
  .hostRd(hostRd), .hostDout(hostDout), .overflowErr(overflowErr),
  .cmdValid(cmdValid), .cmdPush(ctlStb.cmdPush), .dataReady(dataReady)
);

// File: tb/sim_gfxHostIf.sv
module sim_gfxHostIf;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_D = 16;
  localparam int RDQ_D = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostAddr = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostDin = '0, hostDout;
  logic overflowErr, cmdValid, cmdIsCmd;
  logic [7:0] cmdData;
  logic cmdPop = 1'b0, rdqPush = 1'b0;
  logic [7:0] rdqData = '0;
  logic rdqFull;
  logic [4:0] flags = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [8:0] mCmd[$];
  logic [7:0] mRdq[$];
  logic       mOvf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfxHostIf u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostDin(hostDin), .hostDout(hostDout),
    .overflowErr(overflowErr), .cmdValid(cmdValid), .cmdIsCmd(cmdIsCmd),
    .cmdData(cmdData), .cmdPop(cmdPop), .rdqPush(rdqPush),
    .rdqData(rdqData), .rdqFull(rdqFull), .drawBusy(flags[0]),
    .dmaBusy(flags[1]), .vsyncActive(flags[2]), .hblankActive(flags[3]),
    .penValid(flags[4])
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus();
    return {flags, (mCmd.size() == 0), (mCmd.size() == CMD_D), (mRdq.size() != 0)};
  endfunction

  function automatic logic [7:0] expRead(input logic a);
    if (!a) return expStatus();
    return (mRdq.size() != 0) ? mRdq[0] : 8'h00;
  endfunction

  task automatic checkOutputs();
    chk("R1 cmdValid", {15'd0, cmdValid}, {15'd0, mCmd.size() != 0});
    if (mCmd.size() != 0) chk("R1 head", {7'd0, cmdIsCmd, cmdData}, {7'd0, mCmd[0]});
    chk("R3 overflowErr", {15'd0, overflowErr}, {15'd0, mOvf});
    chk("R10 rdqFull", {15'd0, rdqFull}, {15'd0, mRdq.size() == RDQ_D});
  endtask

  // one strobe cycle; all selected actions share a single clock edge
  task automatic cycle(input bit doWr, input logic wA, input logic [7:0] wD,
                       input bit doRd, input logic rA, input bit doCPop,
                       input bit doQPush, input logic [7:0] qD, input string req);
    logic [7:0] exp;
    bit cFull, qFull;
    @(negedge clk);
    hostWr = doWr; hostRd = doRd; cmdPop = doCPop; rdqPush = doQPush;
    hostDin = wD; rdqData = qD;
    hostAddr = doRd ? rA : wA;
    if (doWr && doRd) hostAddr = rA;
    exp = expRead(hostAddr);
    @(negedge clk);
    if (doRd) chk(req, {8'd0, hostDout}, {8'd0, exp});
    cFull = (mCmd.size() == CMD_D);
    qFull = (mRdq.size() == RDQ_D);
    if (doCPop && mCmd.size() != 0) void'(mCmd.pop_front());
    if (doWr) begin
      if (cFull) mOvf = 1'b1;
      else mCmd.push_back({hostAddr, wD});
    end
    if (doRd && hostAddr && mRdq.size() != 0) void'(mRdq.pop_front());
    if (doQPush && !qFull) mRdq.push_back(qD);
    hostWr = 0; hostRd = 0; cmdPop = 0; rdqPush = 0;
    checkOutputs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd7220));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 cmdValid", {15'd0, cmdValid}, 16'd0);
    chk("R9 hostDout", {8'd0, hostDout}, 16'd0);
    chk("R9 overflowErr", {15'd0, overflowErr}, 16'd0);
    chk("R9 rdqFull", {15'd0, rdqFull}, 16'd0);
    flags = 5'b10110;
    cycle(0, 0, 0, 1, 0, 0, 0, 0, "R4 R5 R9 status after reset");

    // R2: write strobe held for three edges -> one entry
    @(negedge clk);
    hostAddr = 1; hostDin = 8'h5A; hostWr = 1;
    repeat (3) @(negedge clk);
    hostWr = 0;
    mCmd.push_back({1'b1, 8'h5A});
    checkOutputs();
    cycle(0, 0, 0, 0, 0, 1, 0, 0, "R2 single pop");
    chk("R2 queue empty after one pop", {15'd0, cmdValid}, 16'd0);

    // R7: data read with empty result queue
    cycle(0, 0, 0, 1, 1, 0, 0, 0, "R7 empty read 00");
    cycle(0, 0, 0, 0, 0, 0, 1, 8'hC3, "R10 push");
    cycle(0, 0, 0, 1, 1, 0, 0, 0, "R6 read C3");
    // R2: read strobe held -> one pop
    cycle(0, 0, 0, 0, 0, 0, 1, 8'h11, "R10 push");
    cycle(0, 0, 0, 0, 0, 0, 1, 8'h22, "R10 push");
    @(negedge clk);
    hostAddr = 1; hostRd = 1;
    repeat (3) @(negedge clk);
    hostRd = 0;
    chk("R2 R6 held read", {8'd0, hostDout}, 16'h0011);
    void'(mRdq.pop_front());
    cycle(0, 0, 0, 1, 1, 0, 0, 0, "R2 R6 second byte");

    // R1 tagging and R3 overflow
    for (int i = 0; i < CMD_D; i++) cycle(1, i[0], 8'(i + 8'h40), 0, 0, 0, 0, 0, "R1 fill");
    cycle(0, 0, 0, 1, 0, 0, 0, 0, "R4 full status");
    cycle(1, 1, 8'hEE, 0, 0, 1, 0, 0, "R3 write+pop while full");
    chk("R3 overflow set", {15'd0, overflowErr}, 16'd1);
    cycle(1, 0, 8'h99, 0, 0, 1, 0, 0, "R10 concurrent write+pop");
    // R8: value holds across writes and pops
    cycle(0, 0, 0, 1, 0, 0, 0, 0, "R8 capture");
    held = hostDout;
    cycle(1, 1, 8'h01, 0, 0, 1, 1, 8'h77, "R8 other activity");
    chk("R8 hostDout held", {8'd0, hostDout}, {8'd0, held});
    for (int i = 0; i < CMD_D; i++) cycle(0, 0, 0, 0, 0, 1, 0, 0, "R1 drain");

    // R10 result queue full, then read+push together
    for (int i = 0; i < RDQ_D + 1; i++) cycle(0, 0, 0, 0, 0, 0, 1, 8'(i + 8'hA0), "R10 fill");
    cycle(0, 0, 0, 1, 1, 0, 1, 8'h5F, "R10 read+push while full");
    cycle(0, 0, 0, 1, 1, 0, 1, 8'h60, "R10 read+push");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      flags = 5'($urandom);
      cycle($urandom_range(0, 99) < 45, 1'($urandom), 8'($urandom),
            $urandom_range(0, 99) < 40, 1'($urandom),
            $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 35,
            8'($urandom), "R1 R4 R5 R6 R7 R10 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule